// File: doc/BRIEF.md
# Page-Latch Write Commit Engine

This block sits between a two-wire serial memory's protocol controller and its byte-wide storage array. While a write transfer is in progress the controller hands it a start address and then a stream of data bytes. The engine keeps the bytes in a 64-entry page latch, together with a per-entry valid mask. Only the low six address bits step from one byte to the next, so a burst that runs past the end of a row wraps back to the start of that same row.

When the controller reports a stop placed immediately after an acknowledge, the engine commits the page in one programming cycle. It first sweeps the latch from row offset 0 to 63 and issues one array write for each valid entry, one per clock. It then holds busy for a programmable number of clock cycles, which stand in for the cell programming time. A stop anywhere else, an abort, or a write-inhibit seen during the data phase throws the latched page away. While busy is high the engine ignores every request, and the controller uses busy to refuse bus traffic, which is the basis for acknowledge polling.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, busy and ram_we are low.
- R2: addr_load sets the row to addr_in[14:6] and the latch offset to addr_in[5:0]. Each accepted byte is stored at the current offset, and the offset then increments. The row never changes because of byte traffic.
- R3: The offset increment wraps from 63 to 0 inside the row. A later byte written to an offset that already holds a byte replaces it.
- R4: A commit_req accepted while at least one entry is valid causes one ram_we pulse per valid entry, and no others. The pulses come in ascending offset order at one per clock, starting the cycle after the request. Each pulse carries ram_addr = {row, offset} and the latched byte as ram_wdata.
- R5: busy rises in the cycle after an accepted commit_req and stays high for exactly 64 + WRITE_CYCLES clock cycles.
- R6: abort while idle discards all latched entries, so a following commit_req with no new bytes produces no writes and no busy.
- R7: A commit_req while no entry is valid starts no programming cycle: busy stays low and no ram_we occurs.
- R8: A byte offered while wr_inhibit is high gets no byte_ack and is not stored. A commit_req in the same session is then discarded with no busy and no writes.
- R9: While busy is high, byte_valid, addr_load, commit_req and abort have no effect, and byte_ack stays low.
- R10: The valid mask is empty after a programming cycle completes, so a repeated commit_req without new bytes produces nothing.
- R11: byte_ack is high in the same cycle as byte_valid exactly when the byte is stored (wr_inhibit low, busy low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load start address from addr_in |
| addr_in | input | 15 | Start byte address (row in upper bits, offset in low 6) |
| byte_valid | input | 1 | Data byte offered this cycle |
| byte_data | input | 8 | Data byte |
| wr_inhibit | input | 1 | Write control active; bytes refused |
| commit_req | input | 1 | Stop seen right after an acknowledge |
| abort | input | 1 | Stop elsewhere or transfer dropped; discard page |
| byte_ack | output | 1 | Byte accepted into the latch |
| busy | output | 1 | Programming cycle in progress |
| ram_we | output | 1 | Array write strobe |
| ram_addr | output | 15 | Array write address |
| ram_wdata | output | 8 | Array write data |

## Verification
The hardest state to reach is a request arriving in the middle of a programming cycle, because that state lasts only while the sweep and the countdown are running. The stimulus reaches it by counting busy cycles from the commit and firing byte_valid, addr_load, abort and commit_req together a few cycles into the sweep. It then checks that every expected write still comes out and that later bytes land at the offset from before the cycle. Row wrap with overwrite is driven by a 70-byte burst that starts mid-row. In that burst some entries are written twice, so the scoreboard must expect the second value in each.

// File: rtl/pce_pkg.sv
package pce_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SWEEP, PH_WAIT} phase_t;

  // offset step inside one row of span entries
  function automatic int unsigned ofs_step(input int unsigned ofs, input int unsigned span);
    return (ofs + 1 >= span) ? 0 : ofs + 1;
  endfunction
endpackage

// File: rtl/pce_page_latch.sv
module pce_page_latch #(
  parameter int PAGE_BYTES = 64,
  localparam int OFS_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             clr,
  input  logic [OFS_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             any_valid
);
  logic [PAGE_BYTES-1:0] mask_q;
  logic [7:0]            data_q [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == OFS_W'(g)) data_q[g] <= wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mask_q[g] <= 1'b0;
      else if (clr)                          mask_q[g] <= 1'b0;
      else if (wr_en && wr_idx == OFS_W'(g)) mask_q[g] <= 1'b1;
    end
  end

  assign rd_data   = data_q[rd_idx];
  assign rd_valid  = mask_q[rd_idx];
  assign any_valid = |mask_q;
endmodule

// File: rtl/pce_commit_seq.sv
module pce_commit_seq
  import pce_pkg::*;
#(
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 250000,
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             busy,
  output logic             sweep_en,
  output logic [OFS_W-1:0] sweep_idx,
  output logic             sweep_last,
  output logic             wait_done
);
  localparam logic [OFS_W-1:0] LAST_IDX = OFS_W'(PAGE_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(WRITE_CYCLES - 1);

  phase_t           phase_q;
  logic [OFS_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (go) begin
          phase_q <= PH_SWEEP;
          idx_q   <= '0;
        end
        PH_SWEEP: if (idx_q == LAST_IDX) begin
          phase_q <= PH_WAIT;
          cnt_q   <= CNT_INIT;
        end else begin
          idx_q <= OFS_W'(ofs_step(int'(idx_q), PAGE_BYTES));
        end
        PH_WAIT: if (cnt_q == '0) phase_q <= PH_IDLE;
                 else             cnt_q   <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy       = (phase_q != PH_IDLE);
  assign sweep_en   = (phase_q == PH_SWEEP);
  assign sweep_idx  = idx_q;
  assign sweep_last = sweep_en && (idx_q == LAST_IDX);
  assign wait_done  = (phase_q == PH_WAIT) && (cnt_q == '0);
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
  import pce_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int PAGE_BYTES   = 64,
  parameter int WRITE_CYCLES = 250000,
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int ROW_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              wr_inhibit,
  input  logic              commit_req,
  input  logic              abort,
  output logic              byte_ack,
  output logic              busy,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  // named internal events, observed by the bound checker
  logic             accept_byte;
  logic             blocked_byte;
  logic             commit_go;
  logic             discard;
  logic             latch_clr;
  logic             any_valid;
  logic             rd_valid;
  logic [7:0]       rd_data;
  logic             sweep_en;
  logic             sweep_last;
  logic             wait_done;
  logic [OFS_W-1:0] sweep_idx;

  logic [ROW_W-1:0] row_q;
  logic [OFS_W-1:0] ofs_q;
  logic             poison_q;

  assign accept_byte  = byte_valid && !busy && !wr_inhibit;
  assign blocked_byte = byte_valid && !busy &&  wr_inhibit;
  assign commit_go    = commit_req && !busy && any_valid && !poison_q;
  assign discard      = !busy && (abort || (commit_req && !commit_go));
  assign latch_clr    = discard || sweep_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q    <= '0;
      ofs_q    <= '0;
      poison_q <= 1'b0;
    end else begin
      if (!busy && addr_load) begin
        row_q <= addr_in[ADDR_W-1:OFS_W];
        ofs_q <= addr_in[OFS_W-1:0];
      end else if (accept_byte) begin
        ofs_q <= OFS_W'(ofs_step(int'(ofs_q), PAGE_BYTES));
      end
      if (discard || commit_go) poison_q <= 1'b0;
      else if (blocked_byte)    poison_q <= 1'b1;
    end
  end

  pce_page_latch #(.PAGE_BYTES(PAGE_BYTES)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (accept_byte),
    .wr_idx    (ofs_q),
    .wr_data   (byte_data),
    .clr       (latch_clr),
    .rd_idx    (sweep_idx),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .any_valid (any_valid)
  );

  pce_commit_seq #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (commit_go),
    .busy       (busy),
    .sweep_en   (sweep_en),
    .sweep_idx  (sweep_idx),
    .sweep_last (sweep_last),
    .wait_done  (wait_done)
  );

  assign byte_ack  = accept_byte;
  assign ram_we    = sweep_en && rd_valid;
  assign ram_addr  = {row_q, sweep_idx};
  assign ram_wdata = rd_data;
endmodule

// File: rtl/page_commit_sva.sv
module page_commit_sva #(
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid,
  input logic              wr_inhibit,
  input logic              byte_ack,
  input logic              busy,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              commit_go,
  input logic              wait_done
);
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (!busy && !ram_we));

  a_r4_we_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);

  a_r4_row_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ram_addr[ADDR_W-1:OFS_W]));

  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we) && $past(busy)) |->
      (ram_addr[OFS_W-1:0] > $past(ram_addr[OFS_W-1:0])));

  a_r5_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_go));

  a_r5_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wait_done));

  a_r8_no_ack_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inhibit |-> !byte_ack);

  a_r9_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ack);

  a_r11_ack_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ack |-> byte_valid);
endmodule

bind page_commit_engine page_commit_sva #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_valid (byte_valid),
  .wr_inhibit (wr_inhibit),
  .byte_ack   (byte_ack),
  .busy       (busy),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr),
  .commit_go  (commit_go),
  .wait_done  (wait_done)
);

// File: tb/page_commit_engine_tb.sv
module page_commit_engine_tb;
  localparam int ADDR_W = 15;
  localparam int PAGE   = 64;
  localparam int WCYC   = 20;
  localparam int BUSY_N = PAGE + WCYC;

  logic clk = 0;
  logic rst_n = 0;
  logic addr_load = 0, byte_valid = 0, wr_inhibit = 0, commit_req = 0, abort = 0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [7:0] byte_data = '0;
  logic byte_ack, busy, ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0] ram_wdata;

  always #10 clk = ~clk;

  page_commit_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_data(byte_data), .wr_inhibit(wr_inhibit),
    .commit_req(commit_req), .abort(abort), .byte_ack(byte_ack), .busy(busy),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model of the page latch
  logic [7:0] m_data [PAGE];
  bit         m_vld  [PAGE];
  int         m_row = 0, m_ofs = 0;
  bit         m_poison = 0;
  logic [ADDR_W+7:0] exp_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: each array write must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      if (exp_q.size() == 0) check(0, "R4 unexpected write", int'({ram_addr, ram_wdata}), 0);
      else begin
        logic [ADDR_W+7:0] e;
        e = exp_q.pop_front();
        check({ram_addr, ram_wdata} == e, "R4 write addr/data", int'({ram_addr, ram_wdata}), int'(e));
      end
    end
  end

  task automatic load_addr(input int a);
    @(negedge clk);
    addr_load = 1; addr_in = ADDR_W'(a);
    m_row = a >> 6; m_ofs = a & 63;
    @(negedge clk);
    addr_load = 0;
  endtask

  // R11: byte_ack shows in the same cycle as byte_valid
  task automatic send_byte(input logic [7:0] d);
    bit exp_ack;
    @(negedge clk);
    byte_valid = 1; byte_data = d;
    exp_ack = !wr_inhibit;
    #1;
    check(byte_ack == exp_ack, wr_inhibit ? "R8 ack refused" : "R11 ack", byte_ack, exp_ack);
    if (exp_ack) begin
      m_data[m_ofs] = d; m_vld[m_ofs] = 1;
      m_ofs = (m_ofs + 1) % PAGE;
    end else m_poison = 1;
    @(negedge clk);
    byte_valid = 0;
  endtask

  function automatic bit model_any();
    foreach (m_vld[i]) if (m_vld[i]) return 1;
    return 0;
  endfunction

  function automatic void model_clear();
    foreach (m_vld[i]) m_vld[i] = 0;
    m_poison = 0;
  endfunction

  task automatic do_abort();
    @(negedge clk);
    abort = 1;
    @(negedge clk);
    abort = 0;
    model_clear();
  endtask

  // commit; inject_at>0 fires all requests in that busy cycle (R9)
  task automatic do_commit(input string req, input int inject_at);
    bit go;
    int cnt;
    go = model_any() && !m_poison;
    @(negedge clk);
    commit_req = 1;
    if (go) begin
      for (int i = 0; i < PAGE; i++)
        if (m_vld[i]) exp_q.push_back({ADDR_W'((m_row << 6) | i), m_data[i]});
    end
    model_clear();
    @(negedge clk);
    commit_req = 0;
    if (!go) begin
      check(busy == 0, req, busy, 0);
      return;
    end
    cnt = 0;
    while (busy && cnt < 10 * BUSY_N) begin
      cnt++;
      if (cnt == inject_at) begin
        byte_valid = 1; byte_data = 8'h77; addr_load = 1; addr_in = 15'h7FFF;
        abort = 1; commit_req = 1;
        #1;
        check(byte_ack == 0, "R9 no ack while busy", byte_ack, 0);
      end
      @(negedge clk);
      byte_valid = 0; addr_load = 0; abort = 0; commit_req = 0;
    end
    check(cnt == BUSY_N, "R5 busy length", cnt, BUSY_N);
    check(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
  endtask

  initial begin
    #(200000 * 20);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(ram_we == 0, "R1 ram_we after reset", ram_we, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0, "R1 idle after release", busy, 0);

    // single byte (R2, R4, R5)
    load_addr(15'h1234);
    send_byte(8'hA5);
    do_commit("R4 byte write", 0);

    // wrap within row: start at offset 62 (R2, R3)
    load_addr(15'h2ABE);
    for (int i = 0; i < 5; i++) send_byte(8'h10 + 8'(i));
    do_commit("R3 wrap", 0);

    // 70 bytes from offset 10: overwrite of offsets 10..15 (R3)
    load_addr(15'h014A);
    for (int i = 0; i < 70; i++) send_byte(8'(i * 3 + 1));
    do_commit("R3 overwrite", 0);

    // abort discards (R6)
    load_addr(15'h0300);
    send_byte(8'h11); send_byte(8'h22);
    do_abort();
    do_commit("R6 abort discards", 0);

    // commit with empty latch (R7)
    do_commit("R7 empty commit", 0);

    // write inhibit poisons the session (R8)
    load_addr(15'h0440);
    send_byte(8'h33);
    wr_inhibit = 1;
    send_byte(8'h44);
    wr_inhibit = 0;
    do_commit("R8 inhibited commit", 0);

    // requests during busy ignored (R9), mask cleared afterward (R10)
    load_addr(15'h0580);
    send_byte(8'h55); send_byte(8'h66);
    do_commit("R9 commit", 5);
    do_commit("R10 mask empty after cycle", 0);
    send_byte(8'h99); // lands at offset 2 of row 0x16 if busy requests were ignored
    do_commit("R9 offset kept", 0);

    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule